// File: doc/BRIEF.md
# Multi-Phase Sampling Clock Selector

This block takes a fast source clock and produces three things from it: a card clock that runs at a quarter or an eighth of the source rate, a transmit launch strobe and a receive sample strobe. Each strobe is one source cycle wide and fires once per card-clock period, at a phase chosen on its own by a coarse/fine phase code. When the source is four times the card clock the phase moves in 90° steps. When it is eight times the card clock the phase moves in 45° steps. In both cases the card clock frequency stays the same. Software settings reach the block as plain input levels.

The control is a three-state machine whose state is the active timing mode. `MODE_FIXED` means tuning is off: the source is divided by 4, transmit sits at 180° and receive at 0°. `MODE_QUAD` means four-phase tuning, dividing by 4. `MODE_OCT` means eight-phase tuning, dividing by 8. The state and both phase indices change only on the source edge that closes the last cycle of a card-clock period, the wrap. At that edge the machine can move between any two states. It goes to `MODE_FIXED` when the tune enable is low. It goes to `MODE_QUAD` when tune is high and the eight-phase enable is low. It goes to `MODE_OCT` when both are high. It may also stay where it is. A 3-bit cycle counter runs through each period. The card clock is high for the first half of the period, and a strobe fires in the cycle where the counter equals that path's phase index.

Top module: `phase_clock_selector`

## Requirements
- R1: While reset is held, the counter is at cycle 0 in `MODE_FIXED`. So `card_clk` is 1, `rx_strobe` is 1 and `tx_strobe` is 0.
- R2: The card-clock period is 8 source cycles in `MODE_OCT` and 4 in the other modes. `card_clk` is high for the first half of the period, starting at cycle 0.
- R3: When `tune_en` is 0, every phase field and `oct_en` are ignored. `tx_strobe` fires in cycle 2 of the 4-cycle period (180°) and `rx_strobe` in cycle 0 (0°).
- R4: In four-phase mode (`tune_en`=1, `oct_en`=0), a coarse code c of 0..3 puts the strobe in cycle c, which is c×90°. The fine bit is ignored.
- R5: In eight-phase mode (`tune_en`=1, `oct_en`=1), the strobe falls in cycle fine×4+coarse, which is (fine×4+coarse)×45°. So fine=1 adds 180°.
- R6: Setting `oct_en`=1 while `tune_en`=0 keeps the 4-cycle period and the fixed phases.
- R7: The transmit and receive phase codes act independently of each other.
- R8: The inputs are sampled only on the source edge that ends the last cycle of a period. A change made earlier in the period has no effect until the next period.
- R9: In every card-clock period, `tx_strobe` and `rx_strobe` are each high for exactly one source cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock, 4x or 8x the card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_en | input | 1 | Phase tuning enable |
| oct_en | input | 1 | Eight-phase enable, used only when tune_en=1 |
| tx_coarse | input | 2 | Transmit coarse phase code |
| tx_fine | input | 1 | Transmit fine (half-period) bit |
| rx_coarse | input | 2 | Receive coarse phase code |
| rx_fine | input | 1 | Receive fine (half-period) bit |
| card_clk | output | 1 | Card clock |
| tx_strobe | output | 1 | Transmit launch strobe, one source cycle wide |
| rx_strobe | output | 1 | Receive sample strobe, one source cycle wide |

## Verification
If the mode state is wrong, the card-clock period length changes, and the first period after the faulty wrap edge shows it within at most 8 source cycles. If a latched phase index is wrong, the strobe moves to another cycle of the period, or appears twice or not at all, and this is visible inside that same period. If the inputs are latched at the wrong time, the strobe moves partway through a period, right after an input change made between wrap edges. The bench compares each output on every source cycle against its own degree-based model and counts the strobes in each period.

// File: rtl/psel_pkg.sv
package psel_pkg;
    typedef enum logic [1:0] {
        MODE_FIXED = 2'd0,
        MODE_QUAD  = 2'd1,
        MODE_OCT   = 2'd2
    } psel_mode_e;
endpackage

// File: rtl/psel_cfg_decode.sv
module psel_cfg_decode
    import psel_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic               tune_en,
    input  logic               oct_en,
    input  logic [CNT_W-2:0]   tx_coarse,
    input  logic               tx_fine,
    input  logic [CNT_W-2:0]   rx_coarse,
    input  logic               rx_fine,
    output psel_mode_e         mode_nxt,
    output logic [CNT_W-1:0]   tx_idx_nxt,
    output logic [CNT_W-1:0]   rx_idx_nxt
);
    localparam int QUAD_P   = 1 << (CNT_W - 1);
    localparam int FIXED_TX = QUAD_P / 2;

    always_comb begin
        if (!tune_en)    mode_nxt = MODE_FIXED;
        else if (oct_en) mode_nxt = MODE_OCT;
        else             mode_nxt = MODE_QUAD;
    end

    always_comb begin
        unique case (mode_nxt)
            MODE_QUAD: begin
                tx_idx_nxt = {1'b0, tx_coarse};
                rx_idx_nxt = {1'b0, rx_coarse};
            end
            MODE_OCT: begin
                tx_idx_nxt = {tx_fine, tx_coarse};
                rx_idx_nxt = {rx_fine, rx_coarse};
            end
            default: begin
                tx_idx_nxt = CNT_W'(FIXED_TX);
                rx_idx_nxt = '0;
            end
        endcase
    end
endmodule

// File: rtl/psel_period_fsm.sv
module psel_period_fsm
    import psel_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  psel_mode_e       mode_nxt,
    input  logic [CNT_W-1:0] tx_idx_nxt,
    input  logic [CNT_W-1:0] rx_idx_nxt,
    output psel_mode_e       mode_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] tx_idx_q,
    output logic [CNT_W-1:0] rx_idx_q
);
    localparam int OCT_P    = 1 << CNT_W;
    localparam int QUAD_P   = OCT_P / 2;
    localparam int FIXED_TX = QUAD_P / 2;

    logic [CNT_W-1:0] last_c;
    logic             wrap;

    always_comb begin
        unique case (mode_q)
            MODE_OCT: last_c = CNT_W'(OCT_P - 1);
            default:  last_c = CNT_W'(QUAD_P - 1);
        endcase
        wrap = (cnt_q == last_c);
    end

    // state register: mode may change only at the period wrap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    mode_q <= MODE_FIXED;
        else if (wrap) mode_q <= mode_nxt;
    end

    // cycle counter and latched phase indices
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            tx_idx_q <= CNT_W'(FIXED_TX);
            rx_idx_q <= '0;
        end else if (wrap) begin
            cnt_q    <= '0;
            tx_idx_q <= tx_idx_nxt;
            rx_idx_q <= rx_idx_nxt;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    // R8: settings hold steady inside a period
    p_hold_mid_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> ($stable(mode_q) && $stable(tx_idx_q) && $stable(rx_idx_q)));

    // R2: counter restarts after the last cycle of the period
    p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == last_c) |=> (cnt_q == '0));

    // R2: four-cycle modes never reach the upper half count
    p_short_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_OCT) |-> (cnt_q < CNT_W'(QUAD_P)));

    // R3: fixed mode keeps default phases
    p_fixed_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FIXED) |-> (tx_idx_q == CNT_W'(FIXED_TX) && rx_idx_q == '0));

    // R9: each index lies inside the period so it is hit once
    p_idx_in_period_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idx_q <= last_c) && (rx_idx_q <= last_c));
endmodule

// File: rtl/psel_strobe_out.sv
module psel_strobe_out
    import psel_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  psel_mode_e       mode_q,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] tx_idx_q,
    input  logic [CNT_W-1:0] rx_idx_q,
    output logic             card_clk,
    output logic             tx_strobe,
    output logic             rx_strobe
);
    localparam int OCT_P  = 1 << CNT_W;
    localparam int QUAD_P = OCT_P / 2;

    always_comb begin
        unique case (mode_q)
            MODE_OCT: card_clk = (cnt_q < CNT_W'(OCT_P / 2));
            default:  card_clk = (cnt_q < CNT_W'(QUAD_P / 2));
        endcase
        tx_strobe = (cnt_q == tx_idx_q);
        rx_strobe = (cnt_q == rx_idx_q);
    end
endmodule

// File: rtl/phase_clock_selector.sv
module phase_clock_selector
    import psel_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tune_en,
    input  logic             oct_en,
    input  logic [CNT_W-2:0] tx_coarse,
    input  logic             tx_fine,
    input  logic [CNT_W-2:0] rx_coarse,
    input  logic             rx_fine,
    output logic             card_clk,
    output logic             tx_strobe,
    output logic             rx_strobe
);
    psel_mode_e       mode_nxt, mode_q;
    logic [CNT_W-1:0] tx_idx_nxt, rx_idx_nxt;
    logic [CNT_W-1:0] cnt_q, tx_idx_q, rx_idx_q;

    psel_cfg_decode #(.CNT_W(CNT_W)) u_dec (
        .tune_en(tune_en), .oct_en(oct_en),
        .tx_coarse(tx_coarse), .tx_fine(tx_fine),
        .rx_coarse(rx_coarse), .rx_fine(rx_fine),
        .mode_nxt(mode_nxt), .tx_idx_nxt(tx_idx_nxt), .rx_idx_nxt(rx_idx_nxt)
    );

    psel_period_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .mode_nxt(mode_nxt), .tx_idx_nxt(tx_idx_nxt), .rx_idx_nxt(rx_idx_nxt),
        .mode_q(mode_q), .cnt_q(cnt_q), .tx_idx_q(tx_idx_q), .rx_idx_q(rx_idx_q)
    );

    psel_strobe_out #(.CNT_W(CNT_W)) u_out (
        .mode_q(mode_q), .cnt_q(cnt_q), .tx_idx_q(tx_idx_q), .rx_idx_q(rx_idx_q),
        .card_clk(card_clk), .tx_strobe(tx_strobe), .rx_strobe(rx_strobe)
    );
endmodule

// File: tb/phase_clock_selector_test.sv
module phase_clock_selector_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tune_en = 1'b0, oct_en = 1'b0;
    logic [1:0] tx_coarse = 2'd0, rx_coarse = 2'd0;
    logic tx_fine = 1'b0, rx_fine = 1'b0;
    logic card_clk, tx_strobe, rx_strobe;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // model state
    int m_cnt = 0, m_per = 4, m_tx = 2, m_rx = 0;
    string m_tag = "R3";
    bit mid_change = 0;
    bit first_period = 1;
    int tx_seen = 0, rx_seen = 0;

    always #10 clk = ~clk;

    phase_clock_selector uut (
        .clk(clk), .rst_n(rst_n), .tune_en(tune_en), .oct_en(oct_en),
        .tx_coarse(tx_coarse), .tx_fine(tx_fine),
        .rx_coarse(rx_coarse), .rx_fine(rx_fine),
        .card_clk(card_clk), .tx_strobe(tx_strobe), .rx_strobe(rx_strobe)
    );

    function automatic int phase_deg(bit tn, bit oc, logic [1:0] c, bit f, bit is_tx);
        if (!tn) return is_tx ? 180 : 0;
        if (!oc) return int'(c) * 90;
        return int'(c) * 45 + (f ? 180 : 0);
    endfunction

    function automatic int period_of(bit tn, bit oc);
        return (tn && oc) ? 8 : 4;
    endfunction

    task automatic chk(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // model of one source edge using inputs currently applied
    task automatic model_step();
        if (m_cnt == m_per - 1) begin
            if (!first_period) begin
                chk(tx_seen, 1, "R9", "tx strobes per period");
                chk(rx_seen, 1, "R9", "rx strobes per period");
            end
            first_period = 0;
            tx_seen = 0;
            rx_seen = 0;
            m_per = period_of(tune_en, oct_en);
            m_tx  = phase_deg(tune_en, oct_en, tx_coarse, tx_fine, 1) * m_per / 360;
            m_rx  = phase_deg(tune_en, oct_en, rx_coarse, rx_fine, 0) * m_per / 360;
            if (!tune_en)   m_tag = oct_en ? "R6" : "R3";
            else if (oct_en) m_tag = "R5";
            else            m_tag = "R4";
            if (tx_coarse != rx_coarse || tx_fine != rx_fine) begin
                if (tune_en) m_tag = {m_tag, "/R7"};
            end
            m_cnt = 0;
            mid_change = 0;
        end else begin
            m_cnt++;
        end
    endtask

    task automatic check_outputs();
        string t;
        t = mid_change ? "R8" : m_tag;
        chk(int'(card_clk), (m_cnt < m_per / 2) ? 1 : 0, "R2", "card_clk");
        chk(int'(tx_strobe), (m_cnt == m_tx) ? 1 : 0, t, "tx_strobe");
        chk(int'(rx_strobe), (m_cnt == m_rx) ? 1 : 0, t, "rx_strobe");
        if (tx_strobe) tx_seen++;
        if (rx_strobe) rx_seen++;
    endtask

    task automatic apply(input bit tn, input bit oc, input logic [1:0] tc, input bit tf,
                         input logic [1:0] rc, input bit rf);
        if (m_cnt != m_per - 1) mid_change = 1;
        tune_en = tn; oct_en = oc;
        tx_coarse = tc; tx_fine = tf;
        rx_coarse = rc; rx_fine = rf;
    endtask

    // one cycle: check at negedge, optionally change inputs, model next edge
    task automatic cycle(input bit do_rand);
        @(negedge clk);
        check_outputs();
        if (do_rand && ($urandom % 8 == 0))
            apply(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                  2'($urandom), 1'($urandom));
        model_step();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle(0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(int'(card_clk), 1, "R1", "card_clk in reset");
        chk(int'(rx_strobe), 1, "R1", "rx_strobe in reset");
        chk(int'(tx_strobe), 0, "R1", "tx_strobe in reset");
        rst_n = 1'b1;
        model_step();

        // R3: fixed phases while fields toggle (fields ignored)
        run(8);
        for (int k = 0; k < 8; k++) begin
            apply(0, 0, 2'(k), 1'(k), 2'(k + 1), 1'(k >> 1));
            run(3);
        end
        // R6: eight-phase enable without tuning
        apply(0, 1, 2'd3, 1, 2'd1, 1);
        run(12);
        // R4 / R7: each four-phase code, tx and rx differing
        for (int c = 0; c < 4; c++) begin
            apply(1, 0, 2'(c), 1, 2'(3 - c), 0);
            run(12);
        end
        // R5: every eight-phase code
        for (int c = 0; c < 8; c++) begin
            apply(1, 1, 2'(c), 1'(c >> 2), 2'(7 - c), 1'((7 - c) >> 2));
            run(20);
        end
        // R3: tuned 180 matches untuned transmit timing
        apply(1, 0, 2'd2, 0, 2'd0, 0);
        run(8);
        apply(0, 0, 2'd0, 0, 2'd0, 0);
        run(8);
        // R8: mid-period change then back to eight-phase
        apply(1, 1, 2'd1, 1, 2'd2, 0);
        run(10);
        // constrained random
        for (int i = 0; i < 3000; i++) cycle(1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule